// File: doc/BRIEF.md
# Masked IR Wake-Pattern Matcher

This block compares decoded infrared messages against a stored pattern and signals a wake-up when one matches. Software loads an 11-byte compare pattern and an 11-byte mask pattern through a two-register window. An index register selects one of the two arrays and a start byte. A data register then writes one byte per access and steps the pointer on by one after each write.

Decoded message bytes arrive on a valid/ready stream. A last flag marks the final byte of each message. Accepted bytes fill a receive buffer in arrival order. When the final byte of a message is accepted, the block compares the buffer, including that byte, with the pattern. Each bit takes part only where its mask bit is 1, and only bytes below the programmed compare length are checked. The block then empties the buffer.

The block keeps four sticky status flags, each cleared by writing 1 to it. An event-enable register chooses which of these flags drive the wake output.

Top module: `irwake_matcher`

## Requirements
- R1: After reset the status output is 0x00, wake is low, the receiver is disabled, the event enables are 0, the compare length is 0, and rx_ready is high.
- R2: Register addresses are: 0 control, 1 status, 2 event enable, 3 index, 4 data, 5 compare length. Index bits [5:4] select the target array: 01 selects compare and 10 selects mask. Index bits [3:0] give the start byte. Each write to the data register stores the byte at the pointer and then increments the pointer. Data writes are ignored when the pointer is 11 or more, or when bits [5:4] are 00 or 11.
- R3: When a byte with rx_last is accepted, status bit 0 (match) is set if, for every byte index i below the compare length, (buffer[i] XOR cmp[i]) AND mask[i] is zero. Buffer byte i is the i-th byte of the message, and is zero if the message had fewer bytes.
- R4: A compare length of 0 always matches. A compare length above 11 compares all 11 bytes.
- R5: Status bit 1 (message end) is set on every accepted last byte. Status bit 2 (buffer full) is set when the 11th byte of a message is stored. Bytes after the 11th are dropped. The buffer is empty again for the next message.
- R6: Writing the status register clears each flag whose bit is set in (wdata AND 0x17). No other bits are affected.
- R7: wake is high exactly when (status[2:0] AND event_enable[2:0]) is non-zero. Event-enable bit 0 gates match, bit 1 gates message end, and bit 2 gates buffer full.
- R8: While control bit 0 is 0, stream bytes and repeat pulses are ignored, and no flag is set.
- R9: A rep_pulse while the receiver is enabled sets status bit 4 (repeat). This flag never drives wake.
- R10: rx_ready is always high, and a byte is taken in every cycle in which rx_valid is high. The stream has no back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | Decoded byte valid |
| rx_ready | output | 1 | Always high; the stream is never stalled |
| rx_data | input | 8 | Decoded message byte |
| rx_last | input | 1 | Marks the final byte of a message |
| rep_pulse | input | 1 | Repeat-code seen strobe |
| status | output | 8 | Sticky flags: bit0 match, bit1 message end, bit2 buffer full, bit4 repeat |
| wake | output | 1 | Wake request |

## Verification
The assertions assume a register write and a stream byte never arrive with the data-pointer write and the index write in the same cycle. They also assume a status clear is never issued in the same cycle as a flag is set. The bench meets both by giving register accesses and message transfers their own cycles. The stimulus mixes random patterns and random lengths with messages built to match under the mask. It also covers lengths past 11 bytes, compare lengths of 0 and above 11, partial array loads, writes to the unused banks, and repeat pulses.

// File: rtl/irwake_pkg.sv
package irwake_pkg;
  localparam int IDXW = 4;
  localparam logic [7:0] CLR_MASK = 8'h17;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_STAT  = 3'd1,
    RA_EVEN  = 3'd2,
    RA_INDEX = 3'd3,
    RA_DATA  = 3'd4,
    RA_CLEN  = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_CMP  = 2'd1,
    BANK_MSK  = 2'd2,
    BANK_BAD  = 2'd3
  } bank_e;

  localparam int ST_MATCH = 0;
  localparam int ST_END   = 1;
  localparam int ST_BUF   = 2;
  localparam int ST_REP   = 4;
endpackage

// File: rtl/irwake_regs.sv
module irwake_regs
  import irwake_pkg::*;
#(
  parameter int NBYTES = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [2:0]      addr,
  input  logic [7:0]      wdata,
  input  logic            set_match,
  input  logic            set_end,
  input  logic            set_buf,
  input  logic            set_rep,
  output logic            rx_en,
  output logic [7:0]      clen,
  output logic [2:0]      even,
  output logic [7:0]      status,
  output logic            pat_we,
  output bank_e           pat_bank,
  output logic [IDXW-1:0] pat_ptr
);
  logic [7:0] clr;
  logic [7:0] sets;
  logic       data_wr;

  assign data_wr = we && (addr == RA_DATA);
  assign pat_we  = data_wr && (pat_bank == BANK_CMP || pat_bank == BANK_MSK)
                   && (pat_ptr < IDXW'(NBYTES));
  assign clr     = (we && addr == RA_STAT) ? (wdata & CLR_MASK) : 8'h00;

  always_comb begin
    sets = 8'h00;
    sets[ST_MATCH] = set_match;
    sets[ST_END]   = set_end;
    sets[ST_BUF]   = set_buf;
    sets[ST_REP]   = set_rep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      clen     <= 8'd0;
      even     <= 3'd0;
      status   <= 8'h00;
      pat_bank <= BANK_NONE;
      pat_ptr  <= '0;
    end else begin
      status <= (status & ~clr) | sets;
      if (we && addr == RA_CTRL) rx_en <= wdata[0];
      if (we && addr == RA_EVEN) even  <= wdata[2:0];
      if (we && addr == RA_CLEN) clen  <= wdata;
      if (we && addr == RA_INDEX) begin
        pat_bank <= bank_e'(wdata[5:4]);
        pat_ptr  <= wdata[IDXW-1:0];
      end else if (data_wr && pat_ptr != '1) begin
        pat_ptr <= pat_ptr + 1'b1;
      end
    end
  end

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && pat_ptr != '1) |=> (pat_ptr == $past(pat_ptr) + 1'b1));
  // R6
  w1c_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == RA_STAT && wdata[ST_MATCH] && !set_match) |=> !status[ST_MATCH]);
endmodule

// File: rtl/irwake_patmem.sv
module irwake_patmem
  import irwake_pkg::*;
#(
  parameter int NBYTES = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  bank_e                  bank,
  input  logic [IDXW-1:0]        ptr,
  input  logic [7:0]             wdata,
  output logic [NBYTES-1:0][7:0] cmp_pat,
  output logic [NBYTES-1:0][7:0] msk_pat
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic hit;
    assign hit = we && (ptr == IDXW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_pat[i] <= 8'h00;
        msk_pat[i] <= 8'h00;
      end else if (hit) begin
        if (bank == BANK_CMP) cmp_pat[i] <= wdata;
        if (bank == BANK_MSK) msk_pat[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/irwake_rxbuf.sv
module irwake_rxbuf #(
  parameter int NBYTES = 11,
  localparam int CW = $clog2(NBYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic                   last,
  input  logic [7:0]             din,
  output logic [NBYTES-1:0][7:0] view,
  output logic                   fill_done
);
  logic [NBYTES-1:0][7:0] buf_q;
  logic [CW-1:0]          cnt_q;

  assign fill_done = take && (cnt_q == CW'(NBYTES - 1));

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic slot;
    assign slot    = take && (cnt_q == CW'(i));
    assign view[i] = slot ? din : buf_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n) buf_q[i] <= 8'h00;
      else if (take && last) buf_q[i] <= 8'h00;
      else if (slot) buf_q[i] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (take && last) cnt_q <= '0;
    else if (take && cnt_q < CW'(NBYTES)) cnt_q <= cnt_q + 1'b1;
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NBYTES));
  // R5
  clear_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |=> (cnt_q == '0));
endmodule

// File: rtl/irwake_cmp.sv
module irwake_cmp #(
  parameter int NBYTES = 11
) (
  input  logic [NBYTES-1:0][7:0] rx_view,
  input  logic [NBYTES-1:0][7:0] cmp_pat,
  input  logic [NBYTES-1:0][7:0] msk_pat,
  input  logic [7:0]             clen,
  output logic                   match
);
  logic [NBYTES-1:0] lane_ok;
  for (genvar i = 0; i < NBYTES; i++) begin : g_cmp
    assign lane_ok[i] = (8'(i) >= clen) ||
                        (((rx_view[i] ^ cmp_pat[i]) & msk_pat[i]) == 8'h00);
  end
  assign match = &lane_ok;
endmodule

// File: rtl/irwake_matcher.sv
module irwake_matcher
  import irwake_pkg::*;
#(
  parameter int NBYTES = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  input  logic       rx_last,
  input  logic       rep_pulse,
  output logic [7:0] status,
  output logic       wake
);
  logic                   rx_en, pat_we, fill_done, match, take;
  logic [7:0]             clen;
  logic [2:0]             even;
  bank_e                  pat_bank;
  logic [IDXW-1:0]        pat_ptr;
  logic [NBYTES-1:0][7:0] cmp_pat, msk_pat, rx_view;

  assign rx_ready = 1'b1;
  assign take     = rx_valid && rx_en;

  irwake_regs #(.NBYTES(NBYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .set_match(take && rx_last && match), .set_end(take && rx_last),
    .set_buf(fill_done), .set_rep(rep_pulse && rx_en),
    .rx_en(rx_en), .clen(clen), .even(even), .status(status),
    .pat_we(pat_we), .pat_bank(pat_bank), .pat_ptr(pat_ptr));

  irwake_patmem #(.NBYTES(NBYTES)) u_pat (
    .clk(clk), .rst_n(rst_n), .we(pat_we), .bank(pat_bank), .ptr(pat_ptr),
    .wdata(reg_wdata), .cmp_pat(cmp_pat), .msk_pat(msk_pat));

  irwake_rxbuf #(.NBYTES(NBYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .take(take), .last(rx_last), .din(rx_data),
    .view(rx_view), .fill_done(fill_done));

  irwake_cmp #(.NBYTES(NBYTES)) u_cmp (
    .rx_view(rx_view), .cmp_pat(cmp_pat), .msk_pat(msk_pat), .clen(clen),
    .match(match));

  assign wake = |(status[2:0] & even);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !reg_we) |=> $stable(status));
  // R5
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rx_last) |=> status[ST_END]);
  // R9
  rep_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_pulse && rx_en) |=> status[ST_REP]);
endmodule

// File: tb/tb_irwake_matcher.sv
module tb_irwake_matcher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_data = 8'd0;
  logic       rx_last = 1'b0;
  logic       rep_pulse = 1'b0;
  logic [7:0] status;
  logic       wake;

  int checks = 0;
  int errors = 0;
  logic [7:0] cmp_m [11];
  logic [7:0] msk_m [11];
  logic [7:0] clen_m;
  logic [7:0] msg [16];
  int unsigned seed_dummy;

  always #5 clk = ~clk;

  irwake_matcher dut (.*);

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = msg[i]; rx_last = (i == n - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  function automatic bit exp_match(input int n);
    for (int i = 0; i < 11; i++) begin
      logic [7:0] b;
      b = (i < n) ? msg[i] : 8'h00;
      if (i < int'(clen_m) && (((b ^ cmp_m[i]) & msk_m[i]) != 8'h00)) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic load_all();
    wr(3'd3, 8'h10);
    for (int i = 0; i < 11; i++) begin cmp_m[i] = 8'($urandom); wr(3'd4, cmp_m[i]); end
    wr(3'd3, 8'h20);
    for (int i = 0; i < 11; i++) begin msk_m[i] = 8'($urandom); wr(3'd4, msk_m[i]); end
  endtask

  task automatic build(input int n, input bit good);
    for (int i = 0; i < 16; i++) begin
      if (i < 11 && good) msg[i] = cmp_m[i] ^ (8'($urandom) & ~msk_m[i]);
      else msg[i] = 8'($urandom);
    end
    if (n < 0) msg[0] = 8'h00;
  endtask

  task automatic msg_check(input string req, input int n);
    bit m;
    m = exp_match(n);
    send(n);
    chk({req, " match"}, int'(status[0]), int'(m));
    chk("R5 end flag", int'(status[1]), 1);
    chk("R5 full flag", int'(status[2]), int'(n >= 11));
    wr(3'd1, 8'h17);
  endtask

  initial begin
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R10 ready
    chk("R1 status", int'(status), 0);
    chk("R1 wake", int'(wake), 0);
    chk("R10 ready", int'(rx_ready), 1);

    // R8 disabled receiver ignores bytes and repeats
    msg[0] = 8'h55; msg[1] = 8'hAA;
    send(2);
    rep_pulse = 1'b1; @(negedge clk); rep_pulse = 1'b0; @(negedge clk);
    chk("R8 disabled status", int'(status), 0);

    // R1 compare length 0 after reset: any message matches
    wr(3'd0, 8'h01);
    clen_m = 8'd0;
    for (int i = 0; i < 11; i++) begin cmp_m[i] = 8'h00; msk_m[i] = 8'h00; end
    msg[0] = 8'hFF; send(1);
    chk("R4 clen0 match", int'(status[0]), 1);
    wr(3'd1, 8'h17);
    chk("R6 cleared", int'(status), 0);

    // R3 random patterns
    load_all();
    clen_m = 8'd11; wr(3'd5, clen_m);
    for (int k = 0; k < 60; k++) begin
      int n;
      n = 1 + int'($urandom % 14);
      if (k % 10 == 9) begin
        clen_m = 8'($urandom % 15); wr(3'd5, clen_m);   // R4 lengths incl. 0 and >11
      end
      build(n, ($urandom % 2) == 0);
      msg_check("R3", n);
      chk("R6 w1c", int'(status), 0);
    end

    // R4 compare length above 11 compares all bytes
    clen_m = 8'd200; wr(3'd5, clen_m);
    build(11, 1'b1); msg_check("R4 long clen", 11);
    msg[10] = msg[10] ^ 8'hFF; msk_m[10] = msk_m[10];
    msg_check("R4 long clen flip", 11);

    // R7 wake gating
    clen_m = 8'd0; wr(3'd5, 8'd0);
    msg[0] = 8'h01; send(1);
    chk("R7 no enable", int'(wake), 0);
    wr(3'd2, 8'h01); chk("R7 match enable", int'(wake), 1);
    wr(3'd2, 8'h02); chk("R7 end enable", int'(wake), 1);
    wr(3'd2, 8'h04); chk("R7 buf enable short", int'(wake), 0);
    wr(3'd1, 8'h01);
    chk("R6 partial clear", int'(status), 8'h02);
    wr(3'd2, 8'h01); chk("R7 match cleared", int'(wake), 0);
    wr(3'd1, 8'hE8);
    chk("R6 outside mask kept", int'(status), 8'h02);
    wr(3'd1, 8'h17);

    // R9 repeat flag, no wake
    wr(3'd2, 8'h07);
    @(negedge clk); rep_pulse = 1'b1; @(negedge clk); rep_pulse = 1'b0;
    chk("R9 repeat set", int'(status), 8'h10);
    chk("R9 no wake", int'(wake), 0);
    wr(3'd1, 8'h10);
    chk("R9 repeat clear", int'(status), 0);
    wr(3'd2, 8'h00);

    // R2 partial load at start address 5 in mask bank
    clen_m = 8'd11; wr(3'd5, clen_m);
    wr(3'd3, 8'h25);
    for (int i = 5; i < 8; i++) begin msk_m[i] = 8'hFF; wr(3'd4, 8'hFF); end
    build(11, 1'b1); msg_check("R2 partial", 11);
    msg[6] = msg[6] ^ 8'h04; msg_check("R2 partial flip", 11);
    // R2 writes to unused banks ignored
    wr(3'd3, 8'h00); for (int i = 0; i < 11; i++) wr(3'd4, 8'h00);
    wr(3'd3, 8'h30); for (int i = 0; i < 11; i++) wr(3'd4, 8'h00);
    build(11, 1'b0); msg_check("R2 bad bank", 11);
    // R2 write past byte 10 ignored, byte 10 written
    wr(3'd3, 8'h1A); cmp_m[10] = 8'h3C; wr(3'd4, 8'h3C); wr(3'd4, 8'hC3);
    msk_m[10] = 8'hFF; wr(3'd3, 8'h2A); wr(3'd4, 8'hFF);
    build(11, 1'b1); msg_check("R2 end of array", 11);
    msg[10] = 8'hC3; msg_check("R2 end of array miss", 11);

    // R5 overlong then short message: buffer restarted
    build(14, 1'b1); msg_check("R5 overlong", 14);
    build(2, 1'b1); msg_check("R5 short after long", 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule